// File: doc/BRIEF.md
# Packed Unsigned 16-bit Minimum Unit

This block is one execution lane of a vector datapath. It receives two 256-bit source vectors, the old 256-bit destination value, a two-bit width mode and a vector-length bit. Every 16-bit lane of the result is the unsigned minimum of the matching lanes of the two sources. The mode decides what happens to bits 255:128. The legacy 128-bit mode keeps the old destination there. The zero-extending 128-bit mode clears them. The 256-bit mode computes all sixteen lanes.

An illegal combination raises an undefined-opcode flag instead of writing a result. The zero-extending mode with the length bit set is illegal, and so is the reserved mode code. Inputs are taken on any cycle with `in_valid` high. The result, the valid strobe and the flag are all registered and appear one clock later. No status or flag outputs exist besides the undefined-opcode indication.

Top module: `vec_umin16`

## Requirements
- R1: Each 16-bit lane is compared as an unsigned integer and the smaller value is returned. When the two operands are equal, that value is returned.
- R2: Mode 2'b00 (legacy 128) computes lanes 0..7 (bits 127:0) from `src_a` and `src_b`, and passes bits 255:128 of `dst_old` through unchanged.
- R3: Mode 2'b01 (zero-extend 128) with `in_len`=0 computes lanes 0..7 and forces bits 255:128 of the result to zero.
- R4: Mode 2'b10 (full 256) computes all sixteen lanes over bits 255:0.
- R5: Mode 2'b01 with `in_len`=1 raises `out_undef` one cycle later and leaves `out_result` unchanged.
- R6: The reserved mode 2'b11 raises `out_undef` one cycle later, whatever the value of `in_len`, and leaves `out_result` unchanged.
- R7: `in_len` has no effect in modes 2'b00 and 2'b10. No flag is raised and the normal result is produced.
- R8: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise. Without `in_valid`, `out_result` holds and `out_undef` is low.
- R9: During and right after an active-low synchronous reset, `out_valid` and `out_undef` are 0 and `out_result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request for this cycle |
| in_mode | input | 2 | 00 legacy-128, 01 zero-extend-128, 10 full-256, 11 reserved |
| in_len | input | 1 | Vector-length bit of the request |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| dst_old | input | 256 | Prior destination contents |
| out_valid | output | 1 | Result or flag is present |
| out_result | output | 256 | Registered lane-wise minimum |
| out_undef | output | 1 | Undefined-opcode indication |

## Verification
The bench builds the unit with its default sixteen lanes of sixteen bits. This is the only configuration in which the three modes differ across a full 256-bit vector, so every mode and the upper-half treatment can be reached. At that width, lanes holding 0x8000 against 0x7FFF and 0x0000 against 0xFFFF make a signed compare give a visibly different answer. Illegal requests are placed straight after legal ones, so that a held result can be told apart from a freshly written one.

// File: rtl/vec_umin16_pkg.sv
package vec_umin16_pkg;

  // Width mode of a request; the encoding is decoded by vec_umin16_dec.
  typedef enum logic [1:0] {
    VM_MERGE128 = 2'b00,
    VM_ZERO128  = 2'b01,
    VM_FULL256  = 2'b10,
    VM_RSVD     = 2'b11
  } vmode_e;

  // What the upper half of the result receives.
  typedef enum logic [1:0] {
    UP_KEEP = 2'b00,
    UP_ZERO = 2'b01,
    UP_CALC = 2'b10
  } upsel_e;

endpackage

// File: rtl/vec_umin16_lane.sv
module vec_umin16_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  // Strictly-less picks the first operand; ties fall to the second.
  function automatic logic [W-1:0] pick_low(input logic [W-1:0] x, input logic [W-1:0] z);
    return (x < z) ? x : z;
  endfunction

  assign y = pick_low(a, b);

endmodule

// File: rtl/vec_umin16_dec.sv
module vec_umin16_dec
  import vec_umin16_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       len,
  output logic       illegal,
  output upsel_e     upper
);

  always_comb begin
    illegal = 1'b0;
    upper   = UP_ZERO;
    case (mode)
      VM_MERGE128: upper = UP_KEEP;
      VM_ZERO128: begin
        upper   = UP_ZERO;
        illegal = len;
      end
      VM_FULL256: upper = UP_CALC;
      default: begin
        upper   = UP_ZERO;
        illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/vec_umin16.sv
module vec_umin16
  import vec_umin16_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_mode,
  input  logic                    in_len,
  input  logic [LANE_W*LANES-1:0] src_a,
  input  logic [LANE_W*LANES-1:0] src_b,
  input  logic [LANE_W*LANES-1:0] dst_old,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] out_result,
  output logic                    out_undef
);

  localparam int VEC_W  = LANE_W * LANES;
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] lane_min;
  logic [VEC_W-1:0] next_result;
  logic             dec_illegal;
  upsel_e           upper_sel;
  logic             accept_ok;

  // One comparator per lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vec_umin16_lane #(.W(LANE_W)) u_lane (
      .a (src_a[g*LANE_W +: LANE_W]),
      .b (src_b[g*LANE_W +: LANE_W]),
      .y (lane_min[g*LANE_W +: LANE_W])
    );
  end

  vec_umin16_dec u_dec (
    .mode    (in_mode),
    .len     (in_len),
    .illegal (dec_illegal),
    .upper   (upper_sel)
  );

  always_comb begin
    next_result[HALF_W-1:0] = lane_min[HALF_W-1:0];
    case (upper_sel)
      UP_KEEP: next_result[VEC_W-1:HALF_W] = dst_old[VEC_W-1:HALF_W];
      UP_CALC: next_result[VEC_W-1:HALF_W] = lane_min[VEC_W-1:HALF_W];
      default: next_result[VEC_W-1:HALF_W] = '0;
    endcase
  end

  assign accept_ok = in_valid & ~dec_illegal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_undef  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      out_undef <= in_valid & dec_illegal;
      if (accept_ok) out_result <= next_result;
    end
  end

endmodule

// File: rtl/vec_umin16_chk.sv
module vec_umin16_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [1:0]              in_mode,
  input logic                    in_len,
  input logic [LANE_W*LANES-1:0] src_a,
  input logic [LANE_W*LANES-1:0] src_b,
  input logic [LANE_W*LANES-1:0] dst_old,
  input logic                    out_valid,
  input logic [LANE_W*LANES-1:0] out_result,
  input logic                    out_undef,
  input logic                    dec_illegal
);

  localparam int VEC_W  = LANE_W * LANES;
  localparam int HALF_W = VEC_W / 2;
  localparam int TOP_LO = VEC_W - LANE_W;

  // R1
  lane0_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_illegal) |=>
      (out_result[LANE_W-1:0] <= $past(src_a[LANE_W-1:0]) &&
       out_result[LANE_W-1:0] <= $past(src_b[LANE_W-1:0])));

  // R2
  merge_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b00) |=>
      out_result[VEC_W-1:HALF_W] == $past(dst_old[VEC_W-1:HALF_W]));

  // R3
  zero_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b01 && !in_len) |=> out_result[VEC_W-1:HALF_W] == '0);

  // R4
  top_lane_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b10) |=>
      (out_result[VEC_W-1:TOP_LO] <= $past(src_a[VEC_W-1:TOP_LO]) &&
       out_result[VEC_W-1:TOP_LO] <= $past(src_b[VEC_W-1:TOP_LO])));

  // R5
  len_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b01 && in_len) |=> (out_undef && $stable(out_result)));

  // R6
  rsvd_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b11) |=> (out_undef && $stable(out_result)));

  // R7
  len_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode[1:0] != 2'b01 && in_mode[1:0] != 2'b11) |=> !out_undef);

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_undef && $stable(out_result)));

  // R9
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_undef && out_result == '0));

endmodule

bind vec_umin16 vec_umin16_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_mode     (in_mode),
  .in_len      (in_len),
  .src_a       (src_a),
  .src_b       (src_b),
  .dst_old     (dst_old),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_undef   (out_undef),
  .dec_illegal (dec_illegal)
);

// File: tb/vec_umin16_bench.sv
module vec_umin16_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   in_mode = 2'b00;
  logic         in_len = 1'b0;
  logic [255:0] src_a = '0;
  logic [255:0] src_b = '0;
  logic [255:0] dst_old = '0;
  logic         out_valid;
  logic [255:0] out_result;
  logic         out_undef;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [255:0] held;

  always #5 clk = ~clk;

  vec_umin16 u_vec_umin16 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode), .in_len(in_len),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .out_valid(out_valid), .out_result(out_result), .out_undef(out_undef)
  );

  // Unsigned minimum through the borrow of a 17-bit subtraction.
  function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] d;
    d = {1'b0, a} - {1'b0, b};
    return d[16] ? a : b;
  endfunction

  function automatic logic [255:0] ref_vec(input logic [1:0] m, input logic [255:0] a,
                                            input logic [255:0] b, input logic [255:0] d);
    logic [255:0] r;
    for (int i = 0; i < 16; i++) r[i*16 +: 16] = ref_lane(a[i*16 +: 16], b[i*16 +: 16]);
    if (m == 2'b00) r[255:128] = d[255:128];
    if (m == 2'b01) r[255:128] = '0;
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  function automatic logic [255:0] splat(input logic [15:0] x);
    logic [255:0] v;
    for (int i = 0; i < 16; i++) v[i*16 +: 16] = x;
    return v;
  endfunction

  task automatic chk_vec(input string req, input logic [255:0] got, input logic [255:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s result got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%b exp=%b", req, what, got, exp);
    end
  endtask

  // Drive one request, then sample after the capturing edge.
  task automatic issue(input logic [1:0] m, input logic l, input logic [255:0] a,
                       input logic [255:0] b, input logic [255:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_len = l; src_a = a; src_b = b; dst_old = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic legal_op(input string req, input logic [1:0] m, input logic l,
                          input logic [255:0] a, input logic [255:0] b, input logic [255:0] d);
    logic [255:0] e;
    e = ref_vec(m, a, b, d);
    issue(m, l, a, b, d);
    chk_vec(req, out_result, e);
    chk_bit(req, "out_valid", out_valid, 1'b1);
    chk_bit(req, "out_undef", out_undef, 1'b0);
    held = e;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_bit("R9", "out_valid", out_valid, 1'b0);
    chk_bit("R9", "out_undef", out_undef, 1'b0);
    chk_vec("R9", out_result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R9", "out_valid after release", out_valid, 1'b0);
    held = '0;
  endtask

  task automatic t_unsigned_edges();
    // Equal lanes, 0x0000 vs 0xFFFF, and 0x8000 vs 0x7FFF (signed compare would differ).
    logic [255:0] a, b;
    a = splat(16'h1234); b = splat(16'h1234);
    legal_op("R1 equal", 2'b10, 1'b0, a, b, '0);
    a = splat(16'h0000); b = splat(16'hFFFF);
    legal_op("R1 zero-vs-max", 2'b10, 1'b0, a, b, '0);
    legal_op("R1 max-vs-zero", 2'b10, 1'b0, b, a, '0);
    a = splat(16'h8000); b = splat(16'h7FFF);
    legal_op("R1 top-bit", 2'b10, 1'b0, a, b, '0);
    chk_vec("R1 top-bit lane value", {240'd0, out_result[15:0]}, {240'd0, 16'h7FFF});
  endtask

  task automatic t_full();
    for (int k = 0; k < 6; k++) legal_op("R4", 2'b10, 1'b0, rnd256(), rnd256(), rnd256());
  endtask

  task automatic t_merge();
    for (int k = 0; k < 4; k++) legal_op("R2", 2'b00, 1'b0, rnd256(), rnd256(), rnd256());
  endtask

  task automatic t_zero();
    for (int k = 0; k < 4; k++) legal_op("R3", 2'b01, 1'b0, rnd256(), rnd256(), rnd256());
  endtask

  task automatic t_undef_len();
    legal_op("R5 setup", 2'b10, 1'b0, rnd256(), rnd256(), rnd256());
    issue(2'b01, 1'b1, '0, '0, '0);
    chk_bit("R5", "out_undef", out_undef, 1'b1);
    chk_bit("R5", "out_valid", out_valid, 1'b1);
    chk_vec("R5 held", out_result, held);
  endtask

  task automatic t_undef_rsvd();
    legal_op("R6 setup", 2'b00, 1'b0, rnd256(), rnd256(), rnd256());
    for (int l = 0; l < 2; l++) begin
      issue(2'b11, l[0], '0, '0, '0);
      chk_bit("R6", "out_undef", out_undef, 1'b1);
      chk_vec("R6 held", out_result, held);
    end
  endtask

  task automatic t_len_ignored();
    legal_op("R7 legacy len=1", 2'b00, 1'b1, rnd256(), rnd256(), rnd256());
    legal_op("R7 full len=1", 2'b10, 1'b1, rnd256(), rnd256(), rnd256());
  endtask

  task automatic t_idle();
    legal_op("R8 setup", 2'b10, 1'b0, rnd256(), rnd256(), '0);
    @(negedge clk);
    src_a = '0; src_b = '0; in_mode = 2'b01;
    @(negedge clk);
    chk_bit("R8", "out_valid idle", out_valid, 1'b0);
    chk_bit("R8", "out_undef idle", out_undef, 1'b0);
    chk_vec("R8 held", out_result, held);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unsigned_edges();
    t_full();
    t_merge();
    t_zero();
    t_undef_len();
    t_undef_rsvd();
    t_len_ignored();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule